// File: doc/BRIEF.md
# ADC Conversion-Read SPI Host

This block is the host side of a serial link to a 12-bit successive-approximation converter. When a start request arrives, it drops chip select and runs one 24-bit SPI frame in mode 0: clock idle low, data launched on the falling edge and sampled on the rising edge. The first eight bits out are a control byte built from the channel, polarity and input-type inputs. The next sixteen bits out are zeros, and during them the converter returns its result. Once the frame is done, chip select goes high again and the 12-bit result is presented with a one-cycle valid strobe.

A run-time divider input sets the serial half-period in system clock cycles. It is clamped into the legal serial clock band of 100 kHz to 2 MHz. A window counter times the span from the end of the control byte to the sampling of the last result bit. It raises a timeout flag with the result when that span is longer than the 120 µs hold limit of the converter's sampler. Start requests that arrive while a frame is running are dropped.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset, cs_n is high, sclk is low, and busy, result_valid and timeout are all low.
- R2: The first 8 bits shifted out on mosi, MSB first, are {1, chan_sel[2:0], unipolar, single_ended, 1, 1}, using the values sampled when start was accepted.
- R3: The 16 bits shifted out after the control byte are all zero.
- R4: mosi changes only while sclk is low, and miso is sampled on each rising edge of sclk.
- R5: The result is bits 14 down to 3 of the last 16 received bits (second received byte in the upper half). The first received byte and the three trailing bits are discarded.
- R6: cs_n stays low for the whole frame with exactly 24 sclk rising edges, and sclk is low whenever cs_n is high. Then cs_n rises and result_valid pulses for one cycle.
- R7: The sclk half-period equals div_half clamped to [32, 625] system cycles (the 2 MHz and 100 kHz limits at a 125 MHz clock).
- R8: timeout is high together with result_valid when the span from the 8th falling sclk edge to the 24th rising edge exceeds 15000 cycles (120 µs). Otherwise it stays low.
- R9: busy is high from the cycle after an accepted start until result_valid. A start raised while busy is ignored and does not change the frame.
- R10: A start raised in the cycle in which result_valid is high is accepted, and a new frame begins on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| chan_sel | input | 3 | Channel selection code for the control byte |
| unipolar | input | 1 | Polarity selection bit for the control byte |
| single_ended | input | 1 | Input-type selection bit for the control byte |
| div_half | input | 16 | Requested sclk half-period in system cycles |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A frame is in progress |
| result | output | 12 | Extracted conversion result |
| result_valid | output | 1 | One-cycle strobe that result is new |
| timeout | output | 1 | Conversion window was exceeded for this result |

## Verification
Frame completion and acceptance of a new request can fall in the same cycle. The result strobe and a start request are both high, so the FSM must retire the old frame and begin the next on the following edge. The bench provokes this by waiting for result_valid and raising start in that same cycle with a different channel and converter value. It then judges both frames by the control byte it captures on mosi and the result it expects, with the timeout flag also checked against the window computed from the clamped divider.

// File: rtl/adc_rd_pkg.sv
// Package: shared types and helpers for the ADC conversion-read host.
// Assumes a 24-bit frame: one control byte followed by two data bytes.
package adc_rd_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_XFER} rd_state_t;

    localparam int FRAME_BITS = 24;
    localparam int CTRL_BITS  = 8;

    // Builds the control byte: start bit, channel, polarity, input type, external-clock code.
    function automatic logic [7:0] make_ctrl(input logic [2:0] ch, input logic uni, input logic sgl);
        return {1'b1, ch, uni, sgl, 2'b11};
    endfunction
endpackage

// File: rtl/adc_rd_tick.sv
// Module: half-period tick generator for the serial clock.
// Assumes half >= 1 and that half stays constant while run is high.
module adc_rd_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half - 1'b1);

    // Counts system cycles within one half-period; restarts whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_rd_shift.sv
// Module: transmit and receive shift registers for one frame.
// Assumes load, rise and fall are mutually exclusive single-cycle strobes.
module adc_rd_shift #(
    parameter int FRAME = 24,
    parameter int CTRL  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTRL-1:0]  ctrl,
    input  logic             rise,
    input  logic             fall,
    input  logic             miso,
    output logic             mosi,
    output logic [FRAME-1:0] rx_word
);
    logic [FRAME-1:0] tx_q;

    assign mosi = tx_q[FRAME-1];

    // Transmit: load control byte and zero padding, advance on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_q <= '0;
        else if (load) tx_q <= {ctrl, {(FRAME-CTRL){1'b0}}};
        else if (fall) tx_q <= {tx_q[FRAME-2:0], 1'b0};
    end

    // Receive: clear at frame start, sample miso on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_word <= '0;
        else if (load) rx_word <= '0;
        else if (rise) rx_word <= {rx_word[FRAME-2:0], miso};
    end
endmodule

// File: rtl/adc_rd_window.sv
// Module: conversion-window timer; flags a span longer than LIMIT cycles.
// Assumes open precedes close within a frame; late holds until the next open.
module adc_rd_window #(
    parameter int LIMIT = 15000,
    parameter int W     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open,
    input  logic close,
    output logic late
);
    logic [W-1:0] cnt_q;
    logic         on_q;

    // Runs a saturating counter between open and close, judging it at close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            on_q  <= 1'b0;
            late  <= 1'b0;
        end else if (open) begin
            cnt_q <= '0;
            on_q  <= 1'b1;
            late  <= 1'b0;
        end else if (close && on_q) begin
            on_q  <= 1'b0;
            late  <= (cnt_q >= W'(LIMIT));
        end else if (on_q && (cnt_q != {W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_read_ctrl.sv
// Module: SPI mode-0 host that runs one 24-bit conversion-read frame per start.
// Assumes the converter launches data on falling sclk; system clock is CLK_HZ.
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int SCLK_MAX_HZ = 2_000_000,
    parameter int SCLK_MIN_HZ = 100_000,
    parameter int WINDOW_US   = 120,
    parameter int DIV_W       = 16,
    parameter int RES_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       chan_sel,
    input  logic             unipolar,
    input  logic             single_ended,
    input  logic [DIV_W-1:0] div_half,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             timeout
);
    localparam int MIN_HALF  = (CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
    localparam int MAX_HALF  = CLK_HZ / (2*SCLK_MIN_HZ);
    localparam int WIN_LIMIT = (CLK_HZ / 1_000_000) * WINDOW_US;
    localparam int WIN_W     = $clog2(WIN_LIMIT + 1) + 1;
    localparam int BIT_W     = $clog2(FRAME_BITS + 1);
    localparam int RES_LSB   = 3;
    localparam int RES_MSB   = RES_LSB + RES_W - 1;

    rd_state_t            state_q;
    logic                 sclk_q;
    logic                 cs_q;
    logic [BIT_W-1:0]     bits_q;
    logic [DIV_W-1:0]     half_q;
    logic [DIV_W-1:0]     half_clamped;
    logic                 tick, rise, fall, accept, late;
    logic [FRAME_BITS-1:0] rx_word;

    assign accept = (state_q == ST_IDLE) && start;
    assign rise   = tick && !sclk_q;
    assign fall   = tick && sclk_q;
    assign sclk   = sclk_q;
    assign cs_n   = cs_q;
    assign busy   = (state_q != ST_IDLE);

    // Clamps the requested half-period into the legal serial clock band.
    always_comb begin
        if (div_half < DIV_W'(MIN_HALF))      half_clamped = DIV_W'(MIN_HALF);
        else if (div_half > DIV_W'(MAX_HALF)) half_clamped = DIV_W'(MAX_HALF);
        else                                  half_clamped = div_half;
    end

    adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q), .tick(tick)
    );

    adc_rd_shift #(.FRAME(FRAME_BITS), .CTRL(CTRL_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .ctrl(make_ctrl(chan_sel, unipolar, single_ended)),
        .rise(rise), .fall(fall), .miso(miso), .mosi(mosi), .rx_word(rx_word)
    );

    adc_rd_window #(.LIMIT(WIN_LIMIT), .W(WIN_W)) u_window (
        .clk(clk), .rst_n(rst_n),
        .open(fall && (bits_q == BIT_W'(CTRL_BITS))),
        .close(rise && (bits_q == BIT_W'(FRAME_BITS - 1))),
        .late(late)
    );

    // Frame sequencer: chip select, sclk phase, bit count and result hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            sclk_q       <= 1'b0;
            cs_q         <= 1'b1;
            bits_q       <= '0;
            half_q       <= DIV_W'(MIN_HALF);
            result       <= '0;
            result_valid <= 1'b0;
            timeout      <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            timeout      <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_XFER;
                        cs_q    <= 1'b0;
                        sclk_q  <= 1'b0;
                        bits_q  <= '0;
                        half_q  <= half_clamped;
                    end
                end
                ST_XFER: begin
                    if (rise) begin
                        sclk_q <= 1'b1;
                        bits_q <= bits_q + 1'b1;
                    end else if (fall) begin
                        sclk_q <= 1'b0;
                        if (bits_q == BIT_W'(FRAME_BITS)) begin
                            state_q      <= ST_IDLE;
                            cs_q         <= 1'b1;
                            result       <= rx_word[RES_MSB:RES_LSB];
                            result_valid <= 1'b1;
                            timeout      <= late;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_read_ctrl_checks.sv
// Module: protocol checker bound to the conversion-read host.
// Assumes synchronous active-low reset; observes ports only.
module adc_read_ctrl_checks (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic busy,
    input logic result_valid,
    input logic timeout
);
    // R6: the serial clock idles low whenever the device is deselected.
    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4: data out holds steady throughout each high phase of sclk.
    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R6: the result strobe lasts a single cycle.
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R9: the result strobe comes with the link released and the block idle.
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (cs_n && !busy));

    // R9: busy only drops when a result is delivered.
    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> result_valid);

    // R8: the timeout flag never appears without a result.
    assert_timeout_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> result_valid);
endmodule

bind adc_read_ctrl adc_read_ctrl_checks u_checks (
    .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .busy(busy), .result_valid(result_valid), .timeout(timeout)
);

// File: tb/adc_read_ctrl_bench.sv
// Bench: scoreboard driven by an issue task, converter model on miso, monitor on result_valid.
module adc_read_ctrl_bench;
    typedef struct {
        logic [7:0]  ctrl;
        logic [11:0] val;
        int          half;
        logic        tmo;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  chan_sel = '0;
    logic        unipolar = 1'b0;
    logic        single_ended = 1'b0;
    logic [15:0] div_half = 16'd32;
    logic        miso = 1'b0;
    logic        sclk, mosi, cs_n, busy, result_valid, timeout;
    logic [11:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    item_t exp_q[$];

    logic [11:0] slave_val = '0;
    logic [23:0] sl_sh = '0;
    logic [23:0] mo_bits = '0;
    int          mo_rises = 0;
    int          t1 = 0;
    int          t2 = 0;
    bit          done = 1'b0;

    adc_read_ctrl u_adc_read_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .unipolar(unipolar), .single_ended(single_ended), .div_half(div_half),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy),
        .result(result), .result_valid(result_valid), .timeout(timeout)
    );

    always #4 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Converter model: first bit at select, next bit after each falling sclk.
    always @(negedge cs_n) begin
        sl_sh = {8'hA5, 1'b0, slave_val, 3'b101};
        miso  = sl_sh[23];
        mo_bits  = '0;
        mo_rises = 0;
    end
    always @(negedge sclk) if (!cs_n) begin
        sl_sh = {sl_sh[22:0], 1'b0};
        miso  = sl_sh[23];
    end

    // Captures host data and edge times at each rising sclk.
    always @(posedge sclk) begin
        mo_bits = {mo_bits[22:0], mosi};
        mo_rises++;
        if (mo_rises == 1) t1 = cyc;
        if (mo_rises == 2) t2 = cyc;
    end

    // Monitor: pops expected item on each result strobe and compares.
    always @(negedge clk) if (rst_n && result_valid) begin
        item_t it;
        check(exp_q.size() != 0, "R9 unexpected frame", 1, 0);
        if (exp_q.size() != 0) begin
            it = exp_q.pop_front();
            check(mo_bits[23:16] == it.ctrl, "R2 control byte", mo_bits[23:16], it.ctrl);
            check(mo_bits[15:0] == 16'h0, "R3 zero padding", mo_bits[15:0], 0);
            check(mo_rises == 24, "R6 rising edge count", mo_rises, 24);
            check((t2 - t1) == 2*it.half, "R7 sclk period", t2 - t1, 2*it.half);
            check(result == it.val, "R5 result (R4 rising-edge sample)", result, it.val);
            check(timeout == it.tmo, "R8 timeout flag", timeout, it.tmo);
            check(cs_n && !busy, "R6 released at strobe", {cs_n, busy}, 2'b10);
        end
    end

    task automatic issue(input logic [2:0] ch, input logic uni, input logic sgl,
                         input logic [15:0] div, input logic [11:0] val, input bit at_valid);
        item_t it;
        it.ctrl = {1'b1, ch, uni, sgl, 2'b11};
        it.val  = val;
        it.half = (div < 32) ? 32 : (div > 625) ? 625 : int'(div);
        it.tmo  = (31 * it.half) > 15000;
        if (at_valid) begin
            do @(negedge clk); while (!result_valid);
        end else begin
            while (busy) @(negedge clk);
        end
        slave_val = val;
        exp_q.push_back(it);
        chan_sel = ch; unipolar = uni; single_ended = sgl; div_half = div;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (at_valid) check(busy && !cs_n, "R10 start on strobe accepted", {busy, cs_n}, 2'b10);
        else          check(busy && !cs_n, "R9 busy after start", {busy, cs_n}, 2'b10);
    endtask

    task automatic wait_done();
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !sclk && !busy && !result_valid && !timeout, "R1 reset state",
              {cs_n, sclk, busy, result_valid, timeout}, 5'b10000);

        issue(3'd3, 1'b1, 1'b1, 16'd32, 12'hABC, 1'b0);
        wait_done();

        issue(3'd0, 1'b0, 1'b0, 16'd0, 12'h001, 1'b0);
        repeat (300) @(negedge clk);
        chan_sel = 3'd7; unipolar = 1'b1; single_ended = 1'b1; slave_val = 12'h001;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !cs_n, "R9 start ignored while busy", {busy, cs_n}, 2'b10);
        wait_done();

        issue(3'd5, 1'b0, 1'b1, 16'd400, 12'hFFF, 1'b0);
        wait_done();
        issue(3'd6, 1'b1, 1'b0, 16'd500, 12'h800, 1'b0);
        wait_done();
        issue(3'd2, 1'b1, 1'b1, 16'd1000, 12'h555, 1'b0);
        wait_done();

        issue(3'd1, 1'b0, 1'b1, 16'd40, 12'h123, 1'b0);
        issue(3'd2, 1'b1, 1'b0, 16'd40, 12'h7E1, 1'b1);
        wait_done();
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 190000) @(negedge clk);
        if (!done) check(1'b0, "watchdog expired", cyc, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule